// File: doc/BRIEF.md
# Multiplexed Clock Display Scanner

This block sends the six BCD digits of a time-of-day counter to a display one digit at a time, over a single shared digit bus. A scan-tick strobe from an external scan-rate source moves the scan forward by one digit. For each digit the block drives a 4-bit BCD code, a 7-bit segment pattern and a one-hot digit enable, all together. The display therefore needs 7 segment lines and 6 enable lines instead of one line per segment per digit.

The scan starts at the units of seconds and ends at the tens of hours. A mode input shortens the scan to four digits, which leaves out both seconds digits. In 12-hour mode a zero in the tens-of-hours digit is blanked. An output-enable input turns off the BCD and segment outputs while the scan keeps running. This lets the display be blanked between digits, or dimmed by pulse-width modulation.

Top module: `clock_digit_scanner`

## Requirements
- R1: After a synchronous active-low reset, the scan position is 0 (units of seconds). In 6-digit mode digitEn reads 6'b000001 until the first scan tick.
- R2: In 4-digit mode (sixDigitMode low) the scan visits positions 2, 3, 4, 5 and then wraps to 2. digitEn[1:0] is never asserted. If the position is 0 or 1 when 4-digit mode is active, digitEn is all zero, segOut is 0 and bcdOut is 4'hF, and the next tick moves to position 2.
- R3: digitEn has at most one bit set. Bit p marks position p, where 0 = units of seconds, 1 = tens of seconds, 2 = units of minutes, 3 = tens of minutes, 4 = units of hours and 5 = tens of hours.
- R4: In 6-digit mode each clock edge that samples scanTick high moves the position by one, in the order 0, 1, 2, 3, 4, 5, and after 5 back to 0.
- R5: When hour12Mode is high and the tens-of-hours digit (digitsBcd[23:20]) is 0 while position 5 is shown, segOut is 0 and bcdOut is 4'hF, and digitEn[5] stays asserted. When hour12Mode is low, a zero in this digit is shown as normal.
- R6: When outEnable is low, segOut is 0 and bcdOut is 4'hF. digitEn and the scan go on unchanged.
- R7: segOut is active high with bit order {g,f,e,d,c,b,a}. The codes for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. BCD codes 10 to 15 give segOut 0.
- R8: On a digit that is not blanked, bcdOut equals digitsBcd[4p+3:4p] for the shown position p, including codes 10 to 15.
- R9: If scanTick is not sampled high at a clock edge, the scan position does not change at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| scanTick | input | 1 | One-cycle strobe that advances the scan |
| digitsBcd | input | 24 | Six BCD digits; position p is in bits [4p+3:4p] |
| sixDigitMode | input | 1 | 1 = scan 6 digits, 0 = scan 4 digits |
| hour12Mode | input | 1 | 1 = 12-hour mode (tens-of-hours zero is blanked) |
| outEnable | input | 1 | 0 = turn off the BCD and segment outputs |
| bcdOut | output | 4 | BCD code of the shown digit; 4'hF when blanked |
| segOut | output | 7 | Segment pattern {g,f,e,d,c,b,a}, active high |
| digitEn | output | 6 | One-hot digit enable; bit p marks position p |

## Verification
Directed sequences run each scan length over several full wraps, both from reset and after the mode changes in the middle of a scan. This separates the 6-digit order from the 4-digit order and exposes a wrong wrap target. A tens-of-hours zero is shown in both hour modes, which tells real blanking apart from a decoder that blanks every zero. Random digit values, including codes 10 to 15, are mixed with random ticks, output-enable drops and mode flips. These catch wrong segment codes, ticks that are missed or counted twice, and any output-enable effect on the scan position.

// File: rtl/scan_pkg.sv
package scan_pkg;
  parameter int NUM_DIGITS = 6;
  parameter int DIGIT_W    = 4;
  parameter int SEG_W      = 7;
  parameter int SKIP_SHORT = 2;   // leading positions dropped in short scan

  typedef struct packed {
    logic [NUM_DIGITS-1:0] digitSel;  // one-hot position strobe
    logic                  active;    // position belongs to current scan
  } scanCtl_t;

  // segment pattern, bit order g f e d c b a, active high
  function automatic logic [SEG_W-1:0] seg7(input logic [DIGIT_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int DIGITS = NUM_DIGITS,
  parameter int SKIP   = SKIP_SHORT
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     scanTick,
  input  logic     sixDigitMode,
  output scanCtl_t ctl
);
  localparam int PTR_W = $clog2(DIGITS);
  localparam logic [PTR_W-1:0] LAST_POS  = PTR_W'(DIGITS - 1);
  localparam logic [PTR_W-1:0] SHORT_POS = PTR_W'(SKIP);

  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptrNext;
  logic [DIGITS-1:0] selOneHot;

  always_comb begin
    if (ptr == LAST_POS)
      ptrNext = sixDigitMode ? '0 : SHORT_POS;
    else if (!sixDigitMode && ptr < SHORT_POS)
      ptrNext = SHORT_POS;
    else
      ptrNext = ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      ptr <= '0;
    else if (scanTick)
      ptr <= ptrNext;
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_sel
    assign selOneHot[i] = (ptr == PTR_W'(i));
  end

  always_comb begin
    ctl.digitSel = selOneHot;
    ctl.active   = sixDigitMode || (ptr >= SHORT_POS);
  end
endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
#(
  parameter int DIGITS = NUM_DIGITS,
  parameter int DW     = DIGIT_W,
  parameter int SW     = SEG_W
) (
  input  scanCtl_t           ctl,
  input  logic [DIGITS*DW-1:0] digitsBcd,
  input  logic               hour12Mode,
  input  logic               outEnable,
  output logic [DW-1:0]      bcdOut,
  output logic [SW-1:0]      segOut,
  output logic [DIGITS-1:0]  digitEn
);
  logic [DW-1:0] masked [DIGITS];
  logic [DW-1:0] digitVal;
  logic          zeroTens;
  logic          blank;

  for (genvar i = 0; i < DIGITS; i++) begin : g_mask
    assign masked[i] = {DW{ctl.digitSel[i]}} & digitsBcd[i*DW +: DW];
  end

  always_comb begin
    digitVal = '0;
    for (int i = 0; i < DIGITS; i++) digitVal = digitVal | masked[i];
  end

  assign zeroTens = ctl.digitSel[DIGITS-1] && hour12Mode && (digitVal == '0);
  assign blank    = !ctl.active || !outEnable || zeroTens;

  assign bcdOut  = blank ? '1 : digitVal;
  assign segOut  = blank ? '0 : seg7(digitVal);
  assign digitEn = ctl.active ? ctl.digitSel : '0;
endmodule

// File: rtl/clock_digit_scanner.sv
module clock_digit_scanner
  import scan_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          scanTick,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digitsBcd,
  input  logic                          sixDigitMode,
  input  logic                          hour12Mode,
  input  logic                          outEnable,
  output logic [DIGIT_W-1:0]            bcdOut,
  output logic [SEG_W-1:0]              segOut,
  output logic [NUM_DIGITS-1:0]         digitEn
);
  scanCtl_t ctl;

  scan_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .scanTick     (scanTick),
    .sixDigitMode (sixDigitMode),
    .ctl          (ctl)
  );

  scan_dp u_dp (
    .ctl        (ctl),
    .digitsBcd  (digitsBcd),
    .hour12Mode (hour12Mode),
    .outEnable  (outEnable),
    .bcdOut     (bcdOut),
    .segOut     (segOut),
    .digitEn    (digitEn)
  );
endmodule

// File: rtl/scan_chk.sv
module scan_chk
  import scan_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          scanTick,
  input logic [NUM_DIGITS*DIGIT_W-1:0] digitsBcd,
  input logic                          sixDigitMode,
  input logic                          hour12Mode,
  input logic                          outEnable,
  input logic [DIGIT_W-1:0]            bcdOut,
  input logic [SEG_W-1:0]              segOut,
  input logic [NUM_DIGITS-1:0]         digitEn
);
  localparam int TOP_LSB = (NUM_DIGITS - 1) * DIGIT_W;

  p_onehot_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(digitEn));

  p_no_secs_short_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sixDigitMode |-> (digitEn[SKIP_SHORT-1:0] == '0));

  p_wrap_long_r4: assert property (@(posedge clk) disable iff (!rstN)
    (scanTick && sixDigitMode && digitEn[NUM_DIGITS-1]) |=>
      (!sixDigitMode || digitEn[0]));

  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!scanTick && sixDigitMode) |=> (!sixDigitMode || $stable(digitEn)));

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> (segOut == '0 && bcdOut == '1));

  p_tens_blank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hour12Mode && digitEn[NUM_DIGITS-1] && digitsBcd[TOP_LSB +: DIGIT_W] == '0)
      |-> (segOut == '0 && bcdOut == '1));
endmodule

bind clock_digit_scanner scan_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .scanTick     (scanTick),
  .digitsBcd    (digitsBcd),
  .sixDigitMode (sixDigitMode),
  .hour12Mode   (hour12Mode),
  .outEnable    (outEnable),
  .bcdOut       (bcdOut),
  .segOut       (segOut),
  .digitEn      (digitEn)
);

// File: tb/tb_clock_digit_scanner.sv
`timescale 1ns/1ps
module tb_clock_digit_scanner;
  logic        clk = 1'b0;
  logic        rstN;
  logic        scanTick;
  logic [23:0] digitsBcd;
  logic        sixDigitMode;
  logic        hour12Mode;
  logic        outEnable;
  logic [3:0]  bcdOut;
  logic [6:0]  segOut;
  logic [5:0]  digitEn;

  int total = 0;
  int bad   = 0;
  int mPtr  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  clock_digit_scanner dut (
    .clk(clk), .rstN(rstN), .scanTick(scanTick), .digitsBcd(digitsBcd),
    .sixDigitMode(sixDigitMode), .hour12Mode(hour12Mode), .outEnable(outEnable),
    .bcdOut(bcdOut), .segOut(segOut), .digitEn(digitEn)
  );

  function automatic logic [6:0] refSeg(input logic [3:0] v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (v < 4'd10) ? t[v] : 7'h00;
  endfunction

  function automatic int refNext(input int p, input logic six);
    if (p == 5) return six ? 0 : 2;
    if (!six && p < 2) return 2;
    return p + 1;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (pos %0d)", tag, act, exp, mPtr);
    end
  endtask

  task automatic checkAll(input logic tk);
    logic       act;
    logic [3:0] d;
    logic       blank;
    string      tag;
    act   = sixDigitMode || (mPtr >= 2);
    d     = digitsBcd[mPtr*4 +: 4];
    blank = !act || !outEnable || (mPtr == 5 && hour12Mode && d == 4'd0);
    if (!act) tag = "R2";
    else if (!outEnable) tag = "R6";
    else if (blank) tag = "R5";
    else if (d > 4'd9) tag = "R7";
    else if (tk) tag = "R4";
    else tag = "R9";
    cmp(act ? "R3" : "R2", digitEn, act ? (1 << mPtr) : 0);
    cmp(blank ? tag : "R8", bcdOut, blank ? 4'hF : d);
    cmp(tag, segOut, blank ? 7'h00 : refSeg(d));
  endtask

  // called right after a negedge; returns at the next negedge
  task automatic cycle(input logic tk);
    scanTick = tk;
    @(posedge clk);
    if (tk) mPtr = refNext(mPtr, sixDigitMode);
    #1;
    checkAll(tk);
    @(negedge clk);
  endtask

  task automatic doReset;
    rstN = 1'b0;
    scanTick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mPtr = 0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    digitsBcd = 24'h095937;   // 09:59:37 as tens-hour..units-sec
    sixDigitMode = 1'b1;
    hour12Mode = 1'b0;
    outEnable = 1'b1;
    doReset();
    #1;
    cmp("R1", digitEn, 6'b000001);   // reset position is units of seconds
    cmp("R1", bcdOut, 4'h7);
    cmp("R1", segOut, 7'h07);

    // R4: two full long scans
    for (int i = 0; i < 13; i++) cycle(1'b1);
    // R9: hold without tick
    for (int i = 0; i < 4; i++) cycle(1'b0);

    // R2: short scan from reset
    sixDigitMode = 1'b0;
    doReset();
    #1;
    cmp("R2", digitEn, 6'b000000);
    cmp("R2", segOut, 7'h00);
    @(negedge clk);
    for (int i = 0; i < 10; i++) cycle(1'b1);

    // R5: tens-hour zero, 12h blanks, 24h shows
    digitsBcd = 24'h012345;
    sixDigitMode = 1'b1;
    while (mPtr != 5) cycle(1'b1);
    hour12Mode = 1'b1;
    cycle(1'b0);
    cmp("R5", digitEn, 6'b100000);
    hour12Mode = 1'b0;
    cycle(1'b0);
    cmp("R5", segOut, 7'h3F);

    // R6: output enable off keeps scanning
    outEnable = 1'b0;
    for (int i = 0; i < 7; i++) cycle(1'b1);
    outEnable = 1'b1;

    // R7/R8: codes 10..15 and all decimal codes
    digitsBcd = 24'hFEDCBA;
    for (int i = 0; i < 6; i++) cycle(1'b1);
    digitsBcd = 24'h987654;
    for (int i = 0; i < 6; i++) cycle(1'b1);
    digitsBcd = 24'h103210;
    for (int i = 0; i < 6; i++) cycle(1'b1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      digitsBcd = $urandom();
      if ($urandom_range(3) == 0) digitsBcd[23:20] = 4'd0;
      outEnable = ($urandom_range(7) != 0);
      if (n % 97 == 0) begin
        sixDigitMode = $urandom_range(1);
        hour12Mode = $urandom_range(1);
      end
      cycle($urandom_range(2) == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule